// File: doc/BRIEF.md
# Skip Condition Program Counter Advance

This block settles how far the program counter moves after a conditional-skip or compare instruction. It also produces the register side effects that some of those instructions carry. A decoder upstream presents a skip operation code with `op_valid`, together with the A and B accumulators, the fetched memory operand, the overflow latch, the sixteen panel switches, a switch selector, the index register, the index-pointer flag and a 4-bit step. One clock later the block returns a registered result. The result holds a program counter advance of 1, 2 or 3 words, write strobes with new values for B, the memory word and the index register, and a strobe that clears the overflow latch.

Words are 16-bit two's complement, with the sign in bit 15. Signed ordering is used wherever magnitude matters. Operation codes on `op_code` are: 0 none, 1 three-way compare of A with memory, 2 three-way sign test of A, 3 skip when no overflow, 4 skip when normalized, 5 increment B, 6 increment memory, 7 skip when switch off, 8 add step to index, 9 A zero, 10 A negative, 11 A positive, 12 index pointer on B. Codes 13 to 15 behave like code 0. On `pc_adv`, the value 1 means the next instruction, 2 skips one instruction and 3 skips two.

Top module: `skip_pc_advance`

## Requirements
- R1: While reset is low, outputs settle to res_valid=0, pc_adv=1, and every write strobe and ovf_clear at 0.
- R2: Each result appears one clock after its op_valid cycle and raises res_valid for that cycle only. Cycles without op_valid give pc_adv=1 with no strobes. Codes 0 and 13 to 15 give pc_adv=1 with no strobes. pc_adv is never 0.
- R3: Code 1 compares A and memory as signed values: A<M gives 1, A=M gives 2, A>M gives 3.
- R4: Code 2 gives 1 when A is negative, 2 when A is zero, and 3 when A is positive and nonzero.
- R5: Code 3 with the overflow latch set raises ovf_clear and gives 1. With the latch clear it gives 2 and leaves ovf_clear low.
- R6: Code 4 gives 2 when A bit 14 differs from A bit 15, and 1 otherwise.
- R7: Code 5 writes B+1 (wrapping) to b_wdata with b_wr. It gives 2 when that value has bit 15 clear, and 1 otherwise.
- R8: Code 6 writes memory+1 (wrapping) to mem_wdata with mem_wr. It gives 2 when that value is zero, and 1 otherwise.
- R9: Code 7 gives 2 when panel_sw[sw_sel] is 0, and 1 when it is 1.
- R10: Code 8 writes the index with bits 3:0 replaced by (bits 3:0 + n_step) mod 16 and bits 15:4 kept, so no carry leaves the nibble. It gives 2 when the new bit 15 is clear, and 1 otherwise.
- R11: Codes 9, 10, 11 and 12 give 2 when, respectively, A is zero, A bit 15 is set, A bit 15 is clear, or idx_ptr_b is high. Otherwise they give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Skip operation code |
| acc_a | input | 16 | A accumulator |
| acc_b | input | 16 | B accumulator |
| mem_rd | input | 16 | Memory operand |
| ovf_latch | input | 1 | Current overflow latch |
| panel_sw | input | 16 | Panel switches, switch k on bit k |
| sw_sel | input | 4 | Selected switch number |
| idx_in | input | 16 | Index register |
| idx_ptr_b | input | 1 | Index pointer currently selects B |
| n_step | input | 4 | Step added to the index nibble |
| res_valid | output | 1 | Result present |
| pc_adv | output | 2 | Program counter advance, 1 to 3 |
| b_wr | output | 1 | Write B |
| b_wdata | output | 16 | New B value |
| mem_wr | output | 1 | Write memory word |
| mem_wdata | output | 16 | New memory word |
| idx_wr | output | 1 | Write index register |
| idx_wdata | output | 16 | New index value |
| ovf_clear | output | 1 | Clear the overflow latch |

## Verification
The hardest case to reach is the index step whose nibble sum overflows. A carry must be dropped without touching bit 15, and the skip must follow the untouched sign. Because the upper bits are forced all ones or all zeros, the bench can tell a leaking carry apart from a correct result. The signed compare is driven with operands that order differently as unsigned numbers, such as 0x7FFF against 0x8000. The increment instructions are driven across the wrap from 0xFFFF to 0 and from 0x7FFF to 0x8000. Random traffic that includes the unused codes then covers back-to-back operations.

// File: rtl/skip_pkg.sv
package skip_pkg;
    typedef enum logic [3:0] {
        SK_NONE   = 4'd0,
        SK_CMP3   = 4'd1,
        SK_SIGN3  = 4'd2,
        SK_NOOVF  = 4'd3,
        SK_NORM   = 4'd4,
        SK_INCB   = 4'd5,
        SK_INCM   = 4'd6,
        SK_SWOFF  = 4'd7,
        SK_IDXN   = 4'd8,
        SK_AZERO  = 4'd9,
        SK_ANEG   = 4'd10,
        SK_APOS   = 4'd11,
        SK_PTRB   = 4'd12
    } skip_op_e;

    localparam logic [1:0] ADV_ONE   = 2'd1;
    localparam logic [1:0] ADV_TWO   = 2'd2;
    localparam logic [1:0] ADV_THREE = 2'd3;
endpackage

// File: rtl/skip_incr_unit.sv
module skip_incr_unit #(
    parameter int W  = 16,
    parameter int NW = 4
) (
    input  logic [W-1:0]  b_val,
    input  logic [W-1:0]  m_val,
    input  logic [W-1:0]  x_val,
    input  logic [NW-1:0] step,
    output logic [W-1:0]  b_next,
    output logic [W-1:0]  m_next,
    output logic [W-1:0]  x_next
);
    assign b_next = b_val + W'(1);
    assign m_next = m_val + W'(1);

    generate
        if (NW >= W) begin : g_whole
            assign x_next = x_val + step[W-1:0];
        end else begin : g_nibble
            logic [NW-1:0] low_sum;
            assign low_sum = x_val[NW-1:0] + step;
            assign x_next  = {x_val[W-1:NW], low_sum};
        end
    endgenerate
endmodule

// File: rtl/skip_cond_unit.sv
module skip_cond_unit
    import skip_pkg::*;
#(
    parameter int W   = 16,
    parameter int SWN = 16,
    parameter int SWW = (SWN > 1) ? $clog2(SWN) : 1
) (
    input  skip_op_e       op,
    input  logic [W-1:0]   a_val,
    input  logic [W-1:0]   m_val,
    input  logic           ovf,
    input  logic [SWN-1:0] sw,
    input  logic [SWW-1:0] sw_idx,
    input  logic           ptr_b,
    input  logic           b_inc_neg,
    input  logic           m_inc_zero,
    input  logic           x_neg,
    output logic [1:0]     adv
);
    logic a_zero;
    logic a_neg;
    logic a_lt_m;
    logic a_eq_m;
    logic sw_on;

    assign a_zero = (a_val == '0);
    assign a_neg  = a_val[W-1];
    assign a_lt_m = $signed(a_val) < $signed(m_val);
    assign a_eq_m = (a_val == m_val);
    assign sw_on  = (int'(sw_idx) < SWN) ? sw[sw_idx] : 1'b0;

    always_comb begin
        adv = ADV_ONE;
        unique case (op)
            SK_CMP3:  adv = a_lt_m ? ADV_ONE : (a_eq_m ? ADV_TWO : ADV_THREE);
            SK_SIGN3: adv = a_neg ? ADV_ONE : (a_zero ? ADV_TWO : ADV_THREE);
            SK_NOOVF: adv = ovf ? ADV_ONE : ADV_TWO;
            SK_NORM:  adv = (a_val[W-2] != a_val[W-1]) ? ADV_TWO : ADV_ONE;
            SK_INCB:  adv = b_inc_neg ? ADV_ONE : ADV_TWO;
            SK_INCM:  adv = m_inc_zero ? ADV_TWO : ADV_ONE;
            SK_SWOFF: adv = sw_on ? ADV_ONE : ADV_TWO;
            SK_IDXN:  adv = x_neg ? ADV_ONE : ADV_TWO;
            SK_AZERO: adv = a_zero ? ADV_TWO : ADV_ONE;
            SK_ANEG:  adv = a_neg ? ADV_TWO : ADV_ONE;
            SK_APOS:  adv = a_neg ? ADV_ONE : ADV_TWO;
            SK_PTRB:  adv = ptr_b ? ADV_TWO : ADV_ONE;
            default:  adv = ADV_ONE;
        endcase
    end
endmodule

// File: rtl/skip_pc_advance.sv
module skip_pc_advance
    import skip_pkg::*;
#(
    parameter int W   = 16,
    parameter int NW  = 4,
    parameter int SWN = 16,
    parameter int SWW = (SWN > 1) ? $clog2(SWN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic [W-1:0]   acc_a,
    input  logic [W-1:0]   acc_b,
    input  logic [W-1:0]   mem_rd,
    input  logic           ovf_latch,
    input  logic [SWN-1:0] panel_sw,
    input  logic [SWW-1:0] sw_sel,
    input  logic [W-1:0]   idx_in,
    input  logic           idx_ptr_b,
    input  logic [NW-1:0]  n_step,
    output logic           res_valid,
    output logic [1:0]     pc_adv,
    output logic           b_wr,
    output logic [W-1:0]   b_wdata,
    output logic           mem_wr,
    output logic [W-1:0]   mem_wdata,
    output logic           idx_wr,
    output logic [W-1:0]   idx_wdata,
    output logic           ovf_clear
);
    typedef struct packed {
        logic         valid;
        logic [1:0]   adv;
        logic         b_we;
        logic [W-1:0] b_val;
        logic         m_we;
        logic [W-1:0] m_val;
        logic         x_we;
        logic [W-1:0] x_val;
        logic         oclr;
    } result_t;

    skip_op_e     op_cur;
    logic [W-1:0] b_inc;
    logic [W-1:0] m_inc;
    logic [W-1:0] x_step;
    logic [1:0]   cond_adv;
    result_t      res_d;
    result_t      res_q;

    assign op_cur = op_valid ? skip_op_e'(op_code) : SK_NONE;

    skip_incr_unit #(.W(W), .NW(NW)) u_incr (
        .b_val  (acc_b),
        .m_val  (mem_rd),
        .x_val  (idx_in),
        .step   (n_step),
        .b_next (b_inc),
        .m_next (m_inc),
        .x_next (x_step)
    );

    skip_cond_unit #(.W(W), .SWN(SWN), .SWW(SWW)) u_cond (
        .op         (op_cur),
        .a_val      (acc_a),
        .m_val      (mem_rd),
        .ovf        (ovf_latch),
        .sw         (panel_sw),
        .sw_idx     (sw_sel),
        .ptr_b      (idx_ptr_b),
        .b_inc_neg  (b_inc[W-1]),
        .m_inc_zero (m_inc == '0),
        .x_neg      (x_step[W-1]),
        .adv        (cond_adv)
    );

    always_comb begin
        res_d       = '0;
        res_d.adv   = ADV_ONE;
        res_d.b_val = b_inc;
        res_d.m_val = m_inc;
        res_d.x_val = x_step;
        if (op_valid) begin
            res_d.valid = 1'b1;
            res_d.adv   = cond_adv;
            case (op_cur)
                SK_INCB:  res_d.b_we = 1'b1;
                SK_INCM:  res_d.m_we = 1'b1;
                SK_IDXN:  res_d.x_we = 1'b1;
                SK_NOOVF: res_d.oclr = ovf_latch;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_q.adv <= ADV_ONE;
        end else begin
            res_q     <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign pc_adv    = res_q.adv;
    assign b_wr      = res_q.b_we;
    assign b_wdata   = res_q.b_val;
    assign mem_wr    = res_q.m_we;
    assign mem_wdata = res_q.m_val;
    assign idx_wr    = res_q.x_we;
    assign idx_wdata = res_q.x_val;
    assign ovf_clear = res_q.oclr;
endmodule

// File: rtl/skip_pc_advance_chk.sv
module skip_pc_advance_chk
    import skip_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] mem_rd,
    input logic         ovf_latch,
    input logic [W-1:0] idx_in,
    input logic         res_valid,
    input logic [1:0]   pc_adv,
    input logic         b_wr,
    input logic         mem_wr,
    input logic [W-1:0] mem_wdata,
    input logic         idx_wr,
    input logic [W-1:0] idx_wdata,
    input logic         ovf_clear
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && pc_adv == 2'd1 && !b_wr && !mem_wr && !idx_wr && !ovf_clear));

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && pc_adv == 2'd1 && !b_wr && !mem_wr && !idx_wr && !ovf_clear));

    assert_adv_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv != 2'd0);

    assert_sign_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'(SK_SIGN3) && acc_a[W-1]) |=> (pc_adv == 2'd1));

    assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'(SK_NOOVF) && ovf_latch) |=> (ovf_clear && pc_adv == 2'd1));

    assert_no_ovf_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'(SK_NOOVF) && !ovf_latch) |=> (!ovf_clear && pc_adv == 2'd2));

    assert_mem_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'(SK_INCM)) |=> (mem_wr && mem_wdata == $past(mem_rd) + W'(1)));

    generate
        if (NW < W) begin : g_hi
            assert_idx_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid && op_code == 4'(SK_IDXN)) |=>
                    (idx_wr && idx_wdata[W-1:NW] == $past(idx_in[W-1:NW])));
        end
    endgenerate
endmodule

bind skip_pc_advance skip_pc_advance_chk #(.W(W), .NW(NW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .acc_a     (acc_a),
    .mem_rd    (mem_rd),
    .ovf_latch (ovf_latch),
    .idx_in    (idx_in),
    .res_valid (res_valid),
    .pc_adv    (pc_adv),
    .b_wr      (b_wr),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .idx_wr    (idx_wr),
    .idx_wdata (idx_wdata),
    .ovf_clear (ovf_clear)
);

// File: tb/sim_skip_pc_advance.sv
`timescale 1ns/1ps
module sim_skip_pc_advance;
    import skip_pkg::*;

    typedef struct {
        logic [1:0]  adv;
        logic        bw;
        logic [15:0] bv;
        logic        mw;
        logic [15:0] mv;
        logic        xw;
        logic [15:0] xv;
        logic        oc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] acc_a = '0, acc_b = '0, mem_rd = '0, idx_in = '0, panel_sw = '0;
    logic        ovf_latch = 1'b0, idx_ptr_b = 1'b0;
    logic [3:0]  sw_sel = '0, n_step = '0;
    logic        res_valid, b_wr, mem_wr, idx_wr, ovf_clear;
    logic [1:0]  pc_adv;
    logic [15:0] b_wdata, mem_wdata, idx_wdata;

    int   checks = 0;
    int   fails = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    skip_pc_advance u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_a(acc_a), .acc_b(acc_b), .mem_rd(mem_rd), .ovf_latch(ovf_latch),
        .panel_sw(panel_sw), .sw_sel(sw_sel), .idx_in(idx_in), .idx_ptr_b(idx_ptr_b),
        .n_step(n_step), .res_valid(res_valid), .pc_adv(pc_adv), .b_wr(b_wr),
        .b_wdata(b_wdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .idx_wr(idx_wr),
        .idx_wdata(idx_wdata), .ovf_clear(ovf_clear)
    );

    function automatic exp_t model(logic [3:0] op, logic [15:0] a, logic [15:0] b,
                                   logic [15:0] m, logic ov, logic [15:0] sw,
                                   logic [3:0] ss, logic [15:0] x, logic pb,
                                   logic [3:0] n, string tag);
        exp_t e;
        e.adv = 2'd1; e.bw = 0; e.bv = '0; e.mw = 0; e.mv = '0;
        e.xw = 0; e.xv = '0; e.oc = 0; e.tag = tag;
        case (op)
            4'd1: begin
                if ($signed(a) < $signed(m)) e.adv = 2'd1;
                else if (a == m) e.adv = 2'd2;
                else e.adv = 2'd3;
            end
            4'd2: e.adv = a[15] ? 2'd1 : ((a == 0) ? 2'd2 : 2'd3);
            4'd3: begin e.oc = ov; e.adv = ov ? 2'd1 : 2'd2; end
            4'd4: e.adv = (a[14] ^ a[15]) ? 2'd2 : 2'd1;
            4'd5: begin e.bw = 1; e.bv = b + 16'd1; e.adv = e.bv[15] ? 2'd1 : 2'd2; end
            4'd6: begin e.mw = 1; e.mv = m + 16'd1; e.adv = (e.mv == 0) ? 2'd2 : 2'd1; end
            4'd7: e.adv = sw[ss] ? 2'd1 : 2'd2;
            4'd8: begin
                e.xw = 1;
                e.xv = {x[15:4], 4'(x[3:0] + n)};
                e.adv = e.xv[15] ? 2'd1 : 2'd2;
            end
            4'd9:  e.adv = (a == 0) ? 2'd2 : 2'd1;
            4'd10: e.adv = a[15] ? 2'd2 : 2'd1;
            4'd11: e.adv = a[15] ? 2'd1 : 2'd2;
            4'd12: e.adv = pb ? 2'd2 : 2'd1;
            default: e.adv = 2'd1;
        endcase
        return e;
    endfunction

    task automatic drive(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic [15:0] m,
                         logic ov, logic [15:0] sw, logic [3:0] ss, logic [15:0] x,
                         logic pb, logic [3:0] n, string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; acc_a = a; acc_b = b; mem_rd = m;
        ovf_latch = ov; panel_sw = sw; sw_sel = ss; idx_in = x; idx_ptr_b = pb; n_step = n;
        sb.push_back(model(op, a, b, m, ov, sw, ss, x, pb, n, tag));
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_code = $urandom_range(0, 15);
        end
    endtask

    // Scoreboard monitor: sampled 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                checks++;
                if (res_valid) begin
                    if (sb.size() == 0) begin
                        fails++;
                        $display("FAIL R2 unexpected result: res_valid=1 expected 0");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (pc_adv !== e.adv || b_wr !== e.bw || mem_wr !== e.mw ||
                            idx_wr !== e.xw || ovf_clear !== e.oc ||
                            (e.bw && b_wdata !== e.bv) || (e.mw && mem_wdata !== e.mv) ||
                            (e.xw && idx_wdata !== e.xv)) begin
                            fails++;
                            $display("FAIL %s: adv=%0d bw=%0b b=%h mw=%0b m=%h xw=%0b x=%h oc=%0b expected adv=%0d bw=%0b b=%h mw=%0b m=%h xw=%0b x=%h oc=%0b",
                                     e.tag, pc_adv, b_wr, b_wdata, mem_wr, mem_wdata, idx_wr,
                                     idx_wdata, ovf_clear, e.adv, e.bw, e.bv, e.mw, e.mv,
                                     e.xw, e.xv, e.oc);
                        end
                    end
                end else if (sb.size() != 0 || pc_adv !== 2'd1 || b_wr || mem_wr || idx_wr || ovf_clear) begin
                    fails++;
                    $display("FAIL R2 idle cycle: valid=%0b adv=%0d pending=%0d expected valid=0 adv=1 pending=0",
                             res_valid, pc_adv, sb.size());
                end
            end
        end
    end

    initial begin
        #1_600_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (res_valid !== 1'b0 || pc_adv !== 2'd1 || b_wr !== 1'b0 || mem_wr !== 1'b0 ||
            idx_wr !== 1'b0 || ovf_clear !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: valid=%0b adv=%0d strobes=%0b%0b%0b%0b expected 0 1 0000",
                     res_valid, pc_adv, b_wr, mem_wr, idx_wr, ovf_clear);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);
        // R2: no-op and unused codes
        drive(4'd0, 16'h1234, 0, 0, 1, 0, 0, 0, 1, 0, "R2 code0");
        drive(4'd14, 16'h0000, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 1, 4'hF, "R2 code14");
        // R3: signed three-way compare
        drive(4'd1, 16'hFFFD, 0, 16'h0002, 0, 0, 0, 0, 0, 0, "R3 less");
        drive(4'd1, 16'h0005, 0, 16'h0005, 0, 0, 0, 0, 0, 0, "R3 equal");
        drive(4'd1, 16'h0002, 0, 16'hFFFD, 0, 0, 0, 0, 0, 0, "R3 greater");
        drive(4'd1, 16'h7FFF, 0, 16'h8000, 0, 0, 0, 0, 0, 0, "R3 extremes");
        // R4: three-way sign
        drive(4'd2, 16'h8000, 0, 0, 0, 0, 0, 0, 0, 0, "R4 negative");
        drive(4'd2, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "R4 zero");
        drive(4'd2, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, "R4 positive");
        idle(1);
        // R5: no-overflow skip
        drive(4'd3, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 latch set");
        drive(4'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 latch clear");
        // R6: normalized
        drive(4'd4, 16'h4000, 0, 0, 0, 0, 0, 0, 0, 0, "R6 01");
        drive(4'd4, 16'hC000, 0, 0, 0, 0, 0, 0, 0, 0, "R6 11");
        drive(4'd4, 16'h8000, 0, 0, 0, 0, 0, 0, 0, 0, "R6 10");
        drive(4'd4, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "R6 00");
        // R7: increment B
        drive(4'd5, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, "R7 to zero");
        drive(4'd5, 0, 16'h7FFF, 0, 0, 0, 0, 0, 0, 0, "R7 to negative");
        drive(4'd5, 0, 16'hFFFD, 0, 0, 0, 0, 0, 0, 0, "R7 still negative");
        // R8: increment memory
        drive(4'd6, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R8 wrap to zero");
        drive(4'd6, 0, 0, 16'h0005, 0, 0, 0, 0, 0, 0, "R8 nonzero");
        // R9: switch off
        drive(4'd7, 0, 0, 0, 0, 16'h0001, 4'd0, 0, 0, 0, "R9 switch0 on");
        drive(4'd7, 0, 0, 0, 0, 16'h7FFF, 4'd15, 0, 0, 0, "R9 switch15 off");
        drive(4'd7, 0, 0, 0, 0, 16'hFFFE, 4'd0, 0, 0, 0, "R9 switch0 off");
        // R10: index nibble step
        drive(4'd8, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0, 4'd1, "R10 carry dropped negative");
        drive(4'd8, 0, 0, 0, 0, 0, 0, 16'h000E, 0, 4'd3, "R10 carry dropped positive");
        drive(4'd8, 0, 0, 0, 0, 0, 0, 16'h8000, 0, 4'd0, "R10 zero step");
        drive(4'd8, 0, 0, 0, 0, 0, 0, 16'h0120, 0, 4'd15, "R10 no carry");
        // R11: single-condition skips
        drive(4'd9, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "R11 zero yes");
        drive(4'd9, 16'h0100, 0, 0, 0, 0, 0, 0, 0, 0, "R11 zero no");
        drive(4'd10, 16'hF000, 0, 0, 0, 0, 0, 0, 0, 0, "R11 neg yes");
        drive(4'd10, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "R11 neg no");
        drive(4'd11, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "R11 pos yes");
        drive(4'd11, 16'h8001, 0, 0, 0, 0, 0, 0, 0, 0, "R11 pos no");
        drive(4'd12, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R11 ptr yes");
        drive(4'd12, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 ptr no");
        idle(2);
        // R2: random back-to-back traffic across all codes
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0) idle(1);
            drive(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom), 16'($urandom),
                  1'($urandom), 16'($urandom), 4'($urandom), 16'($urandom),
                  1'($urandom), 4'($urandom), "R2 random");
        end
        idle(4);
        mon_on = 1'b0;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule